// File: doc/BRIEF.md
# Pipelined zero-turnaround burst SRAM

A synchronous single-port memory of 36-bit words, split into four 9-bit byte lanes of 8 data bits and 1 parity bit each. Every rising clock edge can take a new read or write command. Both directions share the same two-edge latency: write data is sampled two edges after its command, and read data is returned two edges after its command. Because of this, a read can follow a write, or a write can follow a read, with no idle cycle on the data bus.

A command either loads a fresh address and direction, or advances a 2-bit burst counter on the two low address bits. The counter steps in linear order (add and wrap modulo 4) or in interleaved order (XOR with the step count), chosen by a mode input. The shared bus is modelled as a write-data input, a read-data output and a read-output-enable. Storage depth is a parameter. Address bits above the storage index take part in the burst base but select nothing.

Top module: `zbt_sram`

## Requirements
- R1: A read command sampled at edge n drives `rdata_oe` high and `rdata` with the addressed word after edge n+2, with clock enable high at all three edges.
- R2: A write command sampled at edge n stores `wdata` as sampled at edge n+2. Only lanes whose `lane_we` bit was set with the command are updated. Lane i is `wdata[9i+8:9i]`.
- R3: Reads and writes may alternate on consecutive edges with no idle cycle. A read issued one or two cycles after a write to the same word returns the newly written data.
- R4: With `interleave` low, each advance sets the low two address bits to (start + k) mod 4, where k counts the advances since the last load.
- R5: With `interleave` high, each advance sets the low two address bits to start XOR k.
- R6: The fourth advance after a load returns the low bits to the start value, and counting continues from there.
- R7: An advance (`adv` high) ignores `wr` and `addr`. It uses the direction and the upper address bits latched at the last load (`adv` low).
- R8: While `clk_en` is low, no command is taken, no pipeline stage or burst state moves, no write happens, and `rdata`/`rdata_oe` hold their values.
- R9: A command with any `chip_sel` bit low is a deselect. Two enabled edges later `rdata_oe` is low and `rdata` is zero, and no word is written.
- R10: After reset, `rdata_oe` is low, `rdata` is zero, and the burst state is base address 0, step 0, direction read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Clock enable; low freezes the block |
| chip_sel | input | 3 | Chip selects; all must be high for a command |
| addr | input | ADDR_W | Load address |
| wr | input | 1 | 1 = write, 0 = read (on load) |
| adv | input | 1 | 1 = advance burst, 0 = load address |
| lane_we | input | 4 | Per-lane write enables |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| wdata | input | 36 | Write data, sampled two edges after its command |
| rdata | output | 36 | Read data |
| rdata_oe | output | 1 | High while `rdata` carries a read result |

## Verification
Random mixes of loads, advances, deselects and clock-enable stalls run against a bench reference model. Together they check that commands never reorder and never lose their two-edge data slot. Directed write-then-read pairs one and two cycles apart check read-after-write coherence. A partial lane write followed by a read shows whether lane masking touches only the enabled lanes. Six-step bursts from a nonzero start in each mode show whether the XOR order and the add order are apart and whether both wrap. An advance driven with the opposite `wr` level shows whether the loaded direction is kept.

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W = 17,
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic [2:0]        chip_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              adv,
  input  logic [LANES-1:0]  lane_we,
  input  logic              interleave,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  logic [DATA_W-1:0] mem [DEPTH];

  logic             b_wr;
  logic [IDX_W-1:0] b_base;
  logic [1:0]       b_k;
  logic             s1_vld, s1_wr, s2_vld, s2_wr;
  logic [IDX_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0] s1_we, s2_we;

  wire unused_hi = ^addr[ADDR_W-1:IDX_W];

  wire             sel   = &chip_sel;
  wire [1:0]       nxt_k = b_k + 2'd1;
  wire [1:0]       lo    = interleave ? (b_base[1:0] ^ nxt_k) : (b_base[1:0] + nxt_k);
  wire [IDX_W-1:0] eff_a = adv ? {b_base[IDX_W-1:2], lo} : addr[IDX_W-1:0];
  wire             eff_w = adv ? b_wr : wr;
  wire             s2_rd = s2_vld & ~s2_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld <= 1'b0; s1_wr <= 1'b0; s1_addr <= '0; s1_we <= '0;
      s2_vld <= 1'b0; s2_wr <= 1'b0; s2_addr <= '0; s2_we <= '0;
      b_wr <= 1'b0; b_base <= '0; b_k <= '0;
      rdata_oe <= 1'b0; rdata <= '0;
    end else if (clk_en) begin
      s1_vld  <= sel;
      s1_wr   <= eff_w;
      s1_addr <= eff_a;
      s1_we   <= lane_we;
      s2_vld  <= s1_vld;
      s2_wr   <= s1_wr;
      s2_addr <= s1_addr;
      s2_we   <= s1_we;
      if (sel) begin
        if (adv) b_k <= nxt_k;
        else begin
          b_base <= addr[IDX_W-1:0];
          b_k    <= '0;
          b_wr   <= wr;
        end
      end
      rdata_oe <= s2_rd;
      rdata    <= s2_rd ? mem[s2_addr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (clk_en && s2_vld && s2_wr)
      for (int l = 0; l < LANES; l++)
        if (s2_we[l]) mem[s2_addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
  end

  p_read_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && s2_vld && !s2_wr) |=> rdata_oe);
  p_adv_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && sel && adv) |=> (b_k == $past(b_k) + 2'd1));
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && sel && adv && b_k == 2'd3) |=> (b_k == 2'd0 && s1_addr[1:0] == b_base[1:0]));
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && sel && !adv) |=> (s1_addr == $past(addr[IDX_W-1:0]) && s1_wr == $past(wr)));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(rdata_oe) && $stable(rdata)));
  p_desel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !s2_vld) |=> (!rdata_oe && rdata == '0));
endmodule

// File: tb/zbt_sram_tb.sv
module zbt_sram_tb_top;
  localparam int CLK_P = 10;
  localparam int DEPTH = 256;

  logic        clk = 1'b0, rst_n = 1'b0, clk_en = 1'b0;
  logic [2:0]  chip_sel = '0;
  logic [16:0] addr = '0;
  logic        wr = 1'b0, adv = 1'b0, interleave = 1'b0;
  logic [3:0]  lane_we = '0;
  logic [35:0] wdata = '0, rdata;
  logic        rdata_oe;

  always #(CLK_P/2) clk = ~clk;

  zbt_sram dut_i (.clk(clk), .rst_n(rst_n), .clk_en(clk_en), .chip_sel(chip_sel),
    .addr(addr), .wr(wr), .adv(adv), .lane_we(lane_we), .interleave(interleave),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe));

  int checks = 0, failures = 0;
  logic [35:0] mm [DEPTH];
  logic [7:0]  bbase = '0;
  logic [1:0]  bk = '0;
  logic        bw = 1'b0;
  logic        p1v = 0, p1w = 0, p2v = 0, p2w = 0;
  logic [7:0]  p1a = '0, p2a = '0;
  logic [3:0]  p1e = '0, p2e = '0;
  logic        eoe = 1'b0;
  logic [35:0] erd = '0;
  bit          done = 0;

  task automatic check(input string rq);
    checks++;
    if (rdata_oe !== eoe || rdata !== erd) begin
      failures++;
      $display("FAIL %s oe=%b rdata=%h expected oe=%b rdata=%h", rq, rdata_oe, rdata, eoe, erd);
    end
  endtask

  task automatic cyc(input bit ce, input bit [2:0] cs, input bit w, input bit ad,
                     input bit [16:0] a, input bit [3:0] we, input bit md, input string rq);
    logic [1:0] lo;
    @(negedge clk);
    clk_en = ce; chip_sel = cs; wr = w; adv = ad; addr = a; lane_we = we; interleave = md;
    wdata = {4'($urandom), 32'($urandom)};
    @(posedge clk); #1;
    if (ce) begin
      if (p2v && p2w)
        for (int l = 0; l < 4; l++) if (p2e[l]) mm[p2a][l*9 +: 9] = wdata[l*9 +: 9];
      eoe = p2v && !p2w;
      erd = eoe ? mm[p2a] : '0;
      p2v = p1v; p2w = p1w; p2a = p1a; p2e = p1e;
      p1v = &cs; p1e = we;
      if (&cs) begin
        if (ad) begin
          bk = bk + 2'd1;
          lo = md ? (bbase[1:0] ^ bk) : (bbase[1:0] + bk);
          p1a = {bbase[7:2], lo}; p1w = bw;
        end else begin
          bbase = a[7:0]; bk = '0; bw = w; p1a = a[7:0]; p1w = w;
        end
      end
    end
    check(rq);
  endtask

  task automatic rd(input bit [16:0] a, input string rq);  cyc(1, 3'b111, 0, 0, a, 4'h0, 0, rq); endtask
  task automatic wrt(input bit [16:0] a, input bit [3:0] we, input string rq); cyc(1, 3'b111, 1, 0, a, we, 0, rq); endtask
  task automatic stp(input bit md, input bit w, input string rq); cyc(1, 3'b111, w, 1, 17'h1ffff, 4'hF, md, rq); endtask
  task automatic idle(input string rq); cyc(1, 3'b101, 1, 0, 17'h5, 4'hF, 0, rq); endtask
  task automatic drain(input string rq); idle(rq); idle(rq); idle(rq); endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1; check("R10 reset");
    @(negedge clk); rst_n = 1'b1;
    // R2: fill every word with all lanes enabled
    for (int i = 0; i < DEPTH; i++) wrt(17'(i), 4'hF, "R2 fill");
    drain("R2 fill drain");
    for (int i = 0; i < 8; i++) rd(17'(i), "R1 read back");
    drain("R1 drain");
    // R3: write then read one and two cycles later, bus alternating
    wrt(17'h10, 4'hF, "R3"); rd(17'h10, "R3 rd+1"); rd(17'h10, "R3 rd+2");
    wrt(17'h11, 4'hF, "R3"); wrt(17'h12, 4'hF, "R3"); rd(17'h11, "R3 rd+2"); rd(17'h12, "R3 rd+2");
    drain("R3 drain");
    // R2: partial lanes
    wrt(17'h20, 4'b0101, "R2 lanes"); idle("R2"); idle("R2"); rd(17'h20, "R2 lane mask");
    drain("R2 drain");
    // R4/R6 linear burst from start 10
    rd(17'h32, "R4 load");
    for (int i = 0; i < 6; i++) stp(0, 0, "R4 R6 linear");
    drain("R4 drain");
    // R5/R6 interleaved burst from start 01
    rd(17'h41, "R5 load");
    for (int i = 0; i < 6; i++) stp(1, 0, "R5 R6 interleaved");
    drain("R5 drain");
    // R7: write load, advance with wr low stays a write; high addr bits ignored
    wrt(17'h1_0050, 4'hF, "R7 load");
    for (int i = 0; i < 3; i++) stp(0, 0, "R7 adv write");
    rd(17'h50, "R7 verify");
    for (int i = 0; i < 3; i++) stp(0, 1, "R7 adv read");
    drain("R7 drain");
    // R8: stall in the middle of the pipeline
    wrt(17'h60, 4'hF, "R8"); rd(17'h61, "R8");
    cyc(0, 3'b111, 1, 0, 17'h60, 4'hF, 0, "R8 stall");
    cyc(0, 3'b111, 0, 1, 17'h00, 4'hF, 1, "R8 stall");
    rd(17'h60, "R8"); cyc(0, 3'b111, 1, 0, 17'h61, 4'hF, 0, "R8 stall");
    drain("R8 drain");
    // R9: deselects carrying write intent do not write
    for (int i = 0; i < 3; i++) cyc(1, 3'b011 << i, 1, 0, 17'h70, 4'hF, 0, "R9 deselect");
    idle("R9"); rd(17'h70, "R9 no write");
    drain("R9 drain");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit ce = ($urandom % 10) != 0;
      bit [2:0] cs = (($urandom % 10) != 0) ? 3'b111 : 3'($urandom);
      cyc(ce, cs, 1'($urandom), ($urandom % 3) == 0, 17'($urandom), 4'($urandom),
          1'($urandom), "R1 R3 R8 random");
    end
    drain("R1 final drain");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule